// File: doc/BRIEF.md
# Modem Control and Status Unit

This block owns the modem-side handshake of a 16450-style serial port. A control register, written through a simple write port, drives four active-low output lines: data terminal ready, request to send, and two general-purpose outputs. A fifth control bit selects local loopback. Any write with that bit set also tells the serial data path to route its transmit stream internally to the receiver.

On the input side the block passes four active-low modem lines (clear to send, data set ready, ring indicator, carrier detect) through a synchronizer. It then reports their active-high levels in the upper half of a status byte. The lower half holds sticky change flags. Reading the status byte clears these flags. A modem-status interrupt request is raised whenever any flag is set.

In loopback, the four output lines are held at their inactive high level. The status levels are then taken from the control bits instead of the pins, so software can exercise the whole change-flag and interrupt path without a modem attached.

Top module: `modem_ctl_unit`

## Requirements
- R1: While reset is asserted, all four modem output lines are high, the control readback is 0x00, the status byte is 0x00, and both the interrupt request and the loopback control are low.
- R2: Outside loopback, a 1 in control bit 0, 1, 2 or 3 drives low the data-terminal-ready, request-to-send, general output 1 or general output 2 line respectively. A 0 in that bit drives the line high. Control readback returns bits 4:0 as written, and bits 7:5 always read 0.
- R3: Control bit 4 set turns the loopback control output on and forces all four modem output lines high, whatever bits 3:0 hold.
- R4: Status bits 4, 5, 6 and 7 show the inverted clear-to-send, data-set-ready, ring and carrier-detect pins. A pin change shows there exactly SYNC_STAGES+1 clock edges after it is applied, and not one edge earlier.
- R5: Status bits 0 (clear to send), 1 (data set ready) and 3 (carrier detect) set when the matching status level changes in either direction.
- R6: Status bit 2 sets only when the ring pin goes from low to high, which means its status level falls from 1 to 0. The opposite edge leaves bit 2 clear.
- R7: A cycle with the status read strobe high returns the status byte with its flags as they stood before the read. The clock edge that ends that cycle clears bits 3:0.
- R8: A change detected on the same clock edge that ends a status read sets its flag, and the flag remains set after the read.
- R9: The interrupt request is high exactly when any of status bits 3:0 is 1.
- R10: In loopback, the status levels follow the control bits: clear to send from bit 1, data set ready from bit 0, ring from bit 2, carrier detect from bit 3. The pins have no effect on the status byte.
- R11: Change flags are computed on whichever level source is selected. Control writes in loopback, and switching loopback on or off, set flags by the rules of R5 and R6.
- R12: During the first SYNC_STAGES+1 clock edges after reset release, the levels load without setting any flag. A pin held active through reset therefore shows in the status level with no flag and no interrupt.
- R13: A set flag stays set, with no time limit, until a status read clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data |
| ctl_rd_data | output | 8 | Control register readback |
| sts_rd_en | input | 1 | Status read strobe, clears change flags |
| sts_rd_data | output | 8 | Status byte: levels in 7:4, change flags in 3:0 |
| cts_n_in | input | 1 | Clear-to-send pin, active low |
| dsr_n_in | input | 1 | Data-set-ready pin, active low |
| ri_n_in | input | 1 | Ring indicator pin, active low |
| cd_n_in | input | 1 | Carrier-detect pin, active low |
| dtr_n_out | output | 1 | Data-terminal-ready pin, active low |
| rts_n_out | output | 1 | Request-to-send pin, active low |
| op1_n_out | output | 1 | General output 1, active low |
| op2_n_out | output | 1 | General output 2, active low |
| loop_en | output | 1 | Loopback control to the serial data path |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Every internal register of this block reaches a port within one edge. A wrong stored level appears in the status byte immediately. It also produces a spurious or missing change flag, and therefore an interrupt edge, on the next clock edge. A flag that is not cleared, or that is lost when a change and a read meet on the same edge, shows at the read data and on the interrupt request one cycle after the strobe. The synchronizer depth is checked by sampling the status byte exactly at the expected edge and one edge before it. A wrong loopback mapping appears as a status bit that answers the wrong control bit on the edge after the write.

// File: rtl/modem_pkg.sv
`timescale 1ns/1ps
package modem_pkg;
  localparam int unsigned LINES = 4;
  localparam int unsigned CTL_W = 5;
  // line index order inside level / flag vectors
  localparam int unsigned LN_CTS = 0;
  localparam int unsigned LN_DSR = 1;
  localparam int unsigned LN_RI  = 2;
  localparam int unsigned LN_CD  = 3;

  typedef logic [LINES-1:0] line_vec_t;

  // bit 0 = dtr ... bit 4 = loopback
  typedef struct packed {
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } ctl_t;
endpackage

// File: rtl/modem_ctl_reg.sv
`timescale 1ns/1ps
module modem_ctl_reg
  import modem_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned PAD_W = REG_W - CTL_W;

  ctl_t ctl_q, ctl_d;
  logic unused_hi_bits;

  assign unused_hi_bits = ^wr_data[REG_W-1:CTL_W];

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = ctl_t'(wr_data[CTL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl     = ctl_q;
  assign rd_data = {{PAD_W{1'b0}}, ctl_q};

  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctl_q));
  assert_ctl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q == $past(wr_data[CTL_W-1:0])));
endmodule

// File: rtl/modem_pin_sync.sv
`timescale 1ns/1ps
module modem_pin_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_comb stage_d[g] = din;
    end else begin : g_rest
      always_comb stage_d[g] = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/modem_delta_track.sv
`timescale 1ns/1ps
module modem_delta_track
  import modem_pkg::*;
#(
  parameter int unsigned WARM_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lvl_now,
  input  logic      rd_clr,
  output line_vec_t lvl_q,
  output line_vec_t delta_q
);
  localparam int unsigned WARM_W = $clog2(WARM_CYCLES + 1);

  line_vec_t          lvl_r, delta_r, delta_d, chg, set_v;
  logic [WARM_W-1:0]  warm_q, warm_d;
  logic               warm_active;

  assign warm_active = (warm_q != '0);
  assign chg         = lvl_now ^ lvl_r;

  always_comb begin
    set_v          = chg;
    set_v[LN_RI]   = lvl_r[LN_RI] & ~lvl_now[LN_RI];
    if (warm_active) set_v = '0;
    delta_d = (delta_r & ~{LINES{rd_clr}}) | set_v;
    warm_d  = warm_active ? warm_q - 1'b1 : warm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_r   <= '0;
      delta_r <= '0;
      warm_q  <= WARM_W'(WARM_CYCLES);
    end else begin
      lvl_r   <= lvl_now;
      delta_r <= delta_d;
      warm_q  <= warm_d;
    end
  end

  assign lvl_q   = lvl_r;
  assign delta_q = delta_r;

  assert_ri_trailing_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_r[LN_RI]) |-> ($past(lvl_r[LN_RI]) && !lvl_r[LN_RI]));
  assert_cts_flag_on_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(delta_r[LN_CTS]) |-> (lvl_r[LN_CTS] != $past(lvl_r[LN_CTS])));
  assert_flags_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((delta_r & $past(delta_r)) == $past(delta_r)));
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (lvl_now == lvl_r)) |=> (delta_r == '0));
  assert_warm_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    warm_active |=> ((delta_r & ~$past(delta_r)) == '0));
endmodule

// File: rtl/modem_ctl_unit.sv
`timescale 1ns/1ps
module modem_ctl_unit
  import modem_pkg::*;
#(
  parameter int unsigned REG_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wr_data,
  output logic [REG_W-1:0] ctl_rd_data,
  input  logic             sts_rd_en,
  output logic [REG_W-1:0] sts_rd_data,
  input  logic             cts_n_in,
  input  logic             dsr_n_in,
  input  logic             ri_n_in,
  input  logic             cd_n_in,
  output logic             dtr_n_out,
  output logic             rts_n_out,
  output logic             op1_n_out,
  output logic             op2_n_out,
  output logic             loop_en,
  output logic             msi_req
);
  localparam int unsigned WARM_CYCLES = SYNC_STAGES + 1;

  ctl_t      ctl;
  line_vec_t pins_n, sync_n, pin_lvl, loop_lvl, lvl_now, lvl_q, delta_q;

  modem_ctl_reg #(.REG_W(REG_W)) ctl_reg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctl_wr_en),
    .wr_data (ctl_wr_data),
    .ctl     (ctl),
    .rd_data (ctl_rd_data)
  );

  assign pins_n = {cd_n_in, ri_n_in, dsr_n_in, cts_n_in};

  modem_pin_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pins_n),
    .dout  (sync_n)
  );

  always_comb begin
    pin_lvl          = ~sync_n;
    loop_lvl         = '0;
    loop_lvl[LN_CTS] = ctl.rts;
    loop_lvl[LN_DSR] = ctl.dtr;
    loop_lvl[LN_RI]  = ctl.op1;
    loop_lvl[LN_CD]  = ctl.op2;
    lvl_now          = ctl.loop ? loop_lvl : pin_lvl;
  end

  modem_delta_track #(.WARM_CYCLES(WARM_CYCLES)) delta_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_now (lvl_now),
    .rd_clr  (sts_rd_en),
    .lvl_q   (lvl_q),
    .delta_q (delta_q)
  );

  assign dtr_n_out   = ~(ctl.dtr & ~ctl.loop);
  assign rts_n_out   = ~(ctl.rts & ~ctl.loop);
  assign op1_n_out   = ~(ctl.op1 & ~ctl.loop);
  assign op2_n_out   = ~(ctl.op2 & ~ctl.loop);
  assign loop_en     = ctl.loop;
  assign sts_rd_data = {{(REG_W-2*LINES){1'b0}}, lvl_q, delta_q};
  assign msi_req     = |delta_q;

  assert_loop_pins_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (dtr_n_out && rts_n_out && op1_n_out && op2_n_out));
  assert_irq_falls_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msi_req) |-> $past(sts_rd_en));
  assert_loop_cts_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loop_en) && loop_en && !$past(ctl_wr_en)) |-> (sts_rd_data[4] == ctl.rts));
endmodule

// File: tb/modem_ctl_unit_tb.sv
`timescale 1ns/1ps
module modem_ctl_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr_en, sts_rd_en;
  logic [7:0] ctl_wr_data, ctl_rd_data, sts_rd_data;
  logic       cts_n, dsr_n, ri_n, cd_n;
  logic       dtr_n_out, rts_n_out, op1_n_out, op2_n_out, loop_en, msi_req;
  int         n_checks = 0;
  int         n_errors = 0;

  always #2.5 clk = ~clk;

  modem_ctl_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
    .sts_rd_en(sts_rd_en), .sts_rd_data(sts_rd_data),
    .cts_n_in(cts_n), .dsr_n_in(dsr_n), .ri_n_in(ri_n), .cd_n_in(cd_n),
    .dtr_n_out(dtr_n_out), .rts_n_out(rts_n_out), .op1_n_out(op1_n_out),
    .op2_n_out(op2_n_out), .loop_en(loop_en), .msi_req(msi_req)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] out_pins();
    return {4'b0, op2_n_out, op1_n_out, rts_n_out, dtr_n_out};
  endfunction

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_ctl(input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    @(posedge clk); @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic read_sts(output logic [7:0] v);
    sts_rd_en = 1'b1;
    #0.5 v = sts_rd_data;
    @(posedge clk); @(negedge clk);
    sts_rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [3:0] pins_n);
    rst_n = 1'b0;
    {cd_n, ri_n, dsr_n, cts_n} = pins_n;
    ctl_wr_en = 1'b0; ctl_wr_data = 8'h00; sts_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "pins in reset", out_pins(), 8'h0F);
    chk("R1", "ctl readback in reset", ctl_rd_data, 8'h00);
    chk("R1", "status in reset", sts_rd_data, 8'h00);
    chk("R1", "irq/loop in reset", {6'b0, msi_req, loop_en}, 8'h00);
    rst_n = 1'b1;
    edges(6);
  endtask

  task automatic t_ctl_drive();
    write_ctl(8'h05);
    chk("R2", "pins for 0x05", out_pins(), 8'h0A);
    chk("R2", "readback 0x05", ctl_rd_data, 8'h05);
    write_ctl(8'hEA);
    chk("R2", "pins for 0xEA", out_pins(), 8'h05);
    chk("R2", "upper bits read zero", ctl_rd_data, 8'h0A);
    chk("R2", "no loopback", {7'b0, loop_en}, 8'h00);
    write_ctl(8'h00);
    chk("R2", "pins idle", out_pins(), 8'h0F);
  endtask

  task automatic t_levels_edges();
    logic [7:0] v;
    cts_n = 1'b0;
    edges(2);
    chk("R4", "cts one edge early", sts_rd_data, 8'h00);
    edges(1);
    chk("R4", "cts level + R5 flag", sts_rd_data, 8'h11);
    chk("R9", "irq with flag", {7'b0, msi_req}, 8'h01);
    read_sts(v);
    cts_n = 1'b1; edges(3);
    chk("R5", "cts release flag", sts_rd_data, 8'h01);
    read_sts(v);
    cd_n = 1'b0; edges(3);
    chk("R5", "cd assert", sts_rd_data, 8'h88);
    read_sts(v);
    cd_n = 1'b1; edges(3);
    chk("R5", "cd release", sts_rd_data, 8'h08);
    read_sts(v);
    chk("R7", "cleared", sts_rd_data, 8'h00);
  endtask

  task automatic t_ring();
    logic [7:0] v;
    ri_n = 1'b0; edges(3);
    chk("R6", "ri leading edge no flag", sts_rd_data, 8'h40);
    chk("R6", "no irq on leading edge", {7'b0, msi_req}, 8'h00);
    ri_n = 1'b1; edges(3);
    chk("R6", "ri trailing edge flag", sts_rd_data, 8'h04);
    chk("R9", "irq on ri flag", {7'b0, msi_req}, 8'h01);
    read_sts(v);
  endtask

  task automatic t_read_clear();
    logic [7:0] v;
    dsr_n = 1'b0; edges(3);
    read_sts(v);
    chk("R7", "read returns pre-clear", v, 8'h22);
    chk("R7", "flags cleared after read", sts_rd_data, 8'h20);
    chk("R9", "irq drops after read", {7'b0, msi_req}, 8'h00);
    dsr_n = 1'b1; edges(3);
    read_sts(v);
  endtask

  task automatic t_sticky_coincide();
    logic [7:0] v;
    cts_n = 1'b0; edges(3);
    edges(20);
    chk("R13", "flag held without read", sts_rd_data, 8'h11);
    dsr_n = 1'b0;
    edges(2);
    sts_rd_en = 1'b1;
    #0.5 v = sts_rd_data;
    @(posedge clk); @(negedge clk);
    sts_rd_en = 1'b0;
    chk("R8", "read before coincident change", v, 8'h11);
    chk("R8", "coincident flag survives", sts_rd_data, 8'h32);
    read_sts(v);
    cts_n = 1'b1; dsr_n = 1'b1; edges(3);
    read_sts(v);
    chk("R7", "clean before loopback", sts_rd_data, 8'h00);
  endtask

  task automatic t_loopback();
    logic [7:0] v;
    write_ctl(8'h10);
    chk("R3", "loop pins idle", out_pins(), 8'h0F);
    chk("R3", "loop control on", {7'b0, loop_en}, 8'h01);
    edges(1);
    chk("R10", "loop entry levels", sts_rd_data, 8'h00);
    cts_n = 1'b0; edges(4);
    chk("R10", "pins ignored in loop", sts_rd_data, 8'h00);
    write_ctl(8'h11); edges(1);
    chk("R10", "dsr from dtr bit", sts_rd_data, 8'h22);
    chk("R3", "dtr pin held high", out_pins(), 8'h0F);
    read_sts(v);
    write_ctl(8'h12); edges(1);
    chk("R11", "cts from rts bit", sts_rd_data, 8'h13);
    read_sts(v);
    write_ctl(8'h14); edges(1);
    chk("R11", "ri from op1 bit", sts_rd_data, 8'h41);
    read_sts(v);
    write_ctl(8'h18); edges(1);
    chk("R11", "cd from op2, ri trailing", sts_rd_data, 8'h8C);
    read_sts(v);
    write_ctl(8'h08);
    chk("R11", "op2 pin driven after exit", out_pins(), 8'h07);
    edges(1);
    chk("R11", "loop exit flags", sts_rd_data, 8'h19);
    read_sts(v);
    write_ctl(8'h00);
    cts_n = 1'b1; edges(3);
    read_sts(v);
  endtask

  task automatic t_warm();
    do_reset(4'b1110);
    chk("R12", "active pin through reset", sts_rd_data, 8'h10);
    chk("R12", "no irq after reset", {7'b0, msi_req}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired (all requirements): actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    do_reset(4'b1111);
    t_ctl_drive();
    t_levels_edges();
    t_ring();
    t_read_clear();
    t_sticky_coincide();
    t_loopback();
    t_warm();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule